// File: doc/BRIEF.md
# Interrupt Latency History Recorder

This block keeps a short record of the interrupts that a core has accepted, so that debug logic can later see which source was served, how long each one waited, and how far apart successive services were. Every source owns a timestamp register that captures the free-running cycle count whenever that source signals a fresh request. When the core takes an interrupt, the block writes one entry into a circular buffer: the source number, the cycle of the take, and the request timestamp of that source as it stood before the take.

A combinational read port walks the buffer from the most recent entry backwards. The caller supplies a position (0 is the newest), and the block returns the source number, the waiting time (take cycle minus request cycle) and the spacing back to the next newer entry. An entry whose take cycle is zero counts as empty, and it ends the walk. A separate counter totals every take, including those whose entries have since been overwritten.

Top module: `irq_hist_recorder`

## Requirements
- R1: When bit s of `raise_pulse` is high at a rising clock edge, the request timestamp of source s is loaded with `cycle_now`; it is otherwise held, and reset clears it to zero.
- R2: When `take_vld` is high at a rising clock edge, the slot at the write pointer receives `take_idx`, the current `cycle_now` as take time, and the request timestamp of that source as it was before that edge, so a request on the same edge does not affect the stored entry.
- R3: The write pointer advances by one on every take and returns to slot 0 after slot DEPTH-1, so the oldest entry is overwritten once the buffer is full.
- R4: Reset clears every slot to zero, the write pointer to 0 and the take total to 0; afterwards position 0 reads as not valid.
- R5: Read position i addresses slot (write pointer - 1 - i) modulo DEPTH, so position 0 returns the most recent take and position DEPTH-1 the oldest one kept.
- R6: `rd_vld` is high only if `rd_pos` is below DEPTH and every slot at positions 0 up to `rd_pos` has a nonzero take time; when `rd_vld` is low, `rd_idx`, `rd_latency` and `rd_gap` are zero.
- R7: `rd_latency` equals the take time minus the stored request time of the entry, modulo 2^32.
- R8: `rd_gap` is zero at position 0; at position i above 0 it equals the take time at position i-1 minus the take time at position i, modulo 2^32.
- R9: `take_total` increases by one on every take, is otherwise unchanged, and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_now | input | 32 | Free-running cycle count used for all timestamps |
| raise_pulse | input | NUM_SRC | One bit per source, high for a cycle when the source newly requests |
| take_vld | input | 1 | High for one cycle when the core accepts an interrupt |
| take_idx | input | IDX_W | Source number of the accepted interrupt |
| rd_pos | input | POS_W | Read position, 0 is the newest entry |
| rd_vld | output | 1 | Addressed entry exists and no empty slot precedes it |
| rd_idx | output | IDX_W | Source number of the addressed entry |
| rd_latency | output | 32 | Take time minus request time of the addressed entry |
| rd_gap | output | 32 | Take time of the next newer entry minus this entry's take time |
| take_total | output | CNT_W | Count of all takes since reset |

## Verification
The bench aims at the edge where a request and a take for the same source coincide: a design that forwarded the new timestamp into the entry would report a latency of zero instead of the real wait. It drives more takes than the buffer holds, where a pointer that failed to wrap, or a reader that forgot the modulo, would return the wrong source at the oldest positions or lose the newest one. It also reads partly filled buffers and positions past DEPTH, where a reader that ignored the empty-slot rule would report stale zeros as valid entries with bogus gaps, and it checks that position 0 never reports a gap.

// File: rtl/irq_hist_pkg.sv
package irq_hist_pkg;

  // Width of every cycle timestamp handled by the recorder.
  parameter int unsigned HIST_TS_W = 32;

  typedef logic [HIST_TS_W-1:0] stamp_t;

  // Waiting time of one entry: take time minus request time, wrapping.
  function automatic stamp_t calc_latency(input stamp_t taken, input stamp_t raised);
    return taken - raised;
  endfunction

  // Spacing between a newer entry and the entry just older than it.
  function automatic stamp_t calc_gap(input stamp_t newer_taken, input stamp_t older_taken);
    return newer_taken - older_taken;
  endfunction

  // Slot addressed by a read position, counted back from the write pointer.
  function automatic int unsigned slot_of(input int unsigned wr_ptr,
                                          input int unsigned pos,
                                          input int unsigned depth);
    return (wr_ptr + depth - 1 - (pos % depth)) % depth;
  endfunction

  // True when a slot holds a recorded take.
  function automatic logic slot_used(input stamp_t taken);
    return taken != '0;
  endfunction

endpackage

// File: rtl/irq_raise_stamps.sv
module irq_raise_stamps
  import irq_hist_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  stamp_t                        cycle_now,
  input  logic [NUM_SRC-1:0]            raise_pulse,
  output logic [NUM_SRC-1:0][HIST_TS_W-1:0] stamp_q
);

  // One timestamp register per source, loaded on a fresh request.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stamp_q[s] <= '0;
      end else if (raise_pulse[s]) begin
        stamp_q[s] <= cycle_now;
      end
    end
  end

endmodule

// File: rtl/irq_hist_ring.sv
module irq_hist_ring
  import irq_hist_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  stamp_t                          wr_taken,
  input  stamp_t                          wr_raised,
  output logic [PTR_W-1:0]                wr_ptr,
  output logic [DEPTH-1:0][IDX_W-1:0]     ring_idx,
  output logic [DEPTH-1:0][HIST_TS_W-1:0] ring_taken,
  output logic [DEPTH-1:0][HIST_TS_W-1:0] ring_raised
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic ptr_at_end;
  assign ptr_at_end = (wr_ptr == LAST_SLOT);

  // Write pointer: advances on every store, wraps after the last slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= ptr_at_end ? '0 : wr_ptr + 1'b1;
    end
  end

  // Storage slots, each written only when the pointer addresses it.
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_ptr == PTR_W'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ring_idx[k]    <= '0;
        ring_taken[k]  <= '0;
        ring_raised[k] <= '0;
      end else if (hit) begin
        ring_idx[k]    <= wr_idx;
        ring_taken[k]  <= wr_taken;
        ring_raised[k] <= wr_raised;
      end
    end
  end

endmodule

// File: rtl/irq_hist_reader.sv
module irq_hist_reader
  import irq_hist_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int POS_W = PTR_W + 1
) (
  input  logic [PTR_W-1:0]                wr_ptr,
  input  logic [DEPTH-1:0][IDX_W-1:0]     ring_idx,
  input  logic [DEPTH-1:0][HIST_TS_W-1:0] ring_taken,
  input  logic [DEPTH-1:0][HIST_TS_W-1:0] ring_raised,
  input  logic [POS_W-1:0]                rd_pos,
  output logic                            rd_vld,
  output logic [IDX_W-1:0]                rd_idx,
  output stamp_t                          rd_latency,
  output stamp_t                          rd_gap
);

  // Per-position view of the ring, newest first.
  logic [IDX_W-1:0] pos_idx     [DEPTH];
  stamp_t           pos_taken   [DEPTH];
  stamp_t           pos_latency [DEPTH];
  stamp_t           pos_gap     [DEPTH];
  logic             pos_live    [DEPTH];

  logic             pos_in_range;
  logic [PTR_W-1:0] pos_sel;

  always_comb begin
    for (int p = 0; p < DEPTH; p++) begin
      int unsigned slot;
      slot = slot_of(32'(wr_ptr), 32'(p), 32'(DEPTH));
      pos_idx[p]     = ring_idx[slot];
      pos_taken[p]   = ring_taken[slot];
      pos_latency[p] = calc_latency(ring_taken[slot], ring_raised[slot]);
    end
    // Walk stops at the first empty slot.
    for (int p = 0; p < DEPTH; p++) begin
      if (p == 0) begin
        pos_live[p] = slot_used(pos_taken[p]);
        pos_gap[p]  = '0;
      end else begin
        pos_live[p] = pos_live[p-1] && slot_used(pos_taken[p]);
        pos_gap[p]  = calc_gap(pos_taken[p-1], pos_taken[p]);
      end
    end
  end

  assign pos_in_range = (32'(rd_pos) < 32'(DEPTH));
  assign pos_sel      = rd_pos[PTR_W-1:0];

  always_comb begin
    rd_vld     = 1'b0;
    rd_idx     = '0;
    rd_latency = '0;
    rd_gap     = '0;
    if (pos_in_range && pos_live[pos_sel]) begin
      rd_vld     = 1'b1;
      rd_idx     = pos_idx[pos_sel];
      rd_latency = pos_latency[pos_sel];
      rd_gap     = pos_gap[pos_sel];
    end
  end

endmodule

// File: rtl/irq_hist_recorder.sv
module irq_hist_recorder
  import irq_hist_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int POS_W  = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HIST_TS_W-1:0] cycle_now,
  input  logic [NUM_SRC-1:0]   raise_pulse,
  input  logic                 take_vld,
  input  logic [IDX_W-1:0]     take_idx,
  input  logic [POS_W-1:0]     rd_pos,
  output logic                 rd_vld,
  output logic [IDX_W-1:0]     rd_idx,
  output logic [HIST_TS_W-1:0] rd_latency,
  output logic [HIST_TS_W-1:0] rd_gap,
  output logic [CNT_W-1:0]     take_total
);

  // Named internal events, also observed by the bound checker.
  logic                                take_fire;
  stamp_t                              raised_sel;
  logic [PTR_W-1:0]                    wr_ptr;
  logic [NUM_SRC-1:0][HIST_TS_W-1:0]   stamp_q;
  logic [DEPTH-1:0][IDX_W-1:0]         ring_idx;
  logic [DEPTH-1:0][HIST_TS_W-1:0]     ring_taken;
  logic [DEPTH-1:0][HIST_TS_W-1:0]     ring_raised;

  assign take_fire = take_vld;

  // Request time of the source being taken, as held before this edge.
  always_comb begin
    raised_sel = '0;
    if (32'(take_idx) < 32'(NUM_SRC)) begin
      raised_sel = stamp_q[take_idx];
    end
  end

  irq_raise_stamps #(
    .NUM_SRC (NUM_SRC)
  ) stamps_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_now   (cycle_now),
    .raise_pulse (raise_pulse),
    .stamp_q     (stamp_q)
  );

  irq_hist_ring #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) ring_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (take_fire),
    .wr_idx      (take_idx),
    .wr_taken    (cycle_now),
    .wr_raised   (raised_sel),
    .wr_ptr      (wr_ptr),
    .ring_idx    (ring_idx),
    .ring_taken  (ring_taken),
    .ring_raised (ring_raised)
  );

  irq_hist_reader #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) reader_i (
    .wr_ptr      (wr_ptr),
    .ring_idx    (ring_idx),
    .ring_taken  (ring_taken),
    .ring_raised (ring_raised),
    .rd_pos      (rd_pos),
    .rd_vld      (rd_vld),
    .rd_idx      (rd_idx),
    .rd_latency  (rd_latency),
    .rd_gap      (rd_gap)
  );

  // Running total of takes, wrapping at its width.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_total <= '0;
    end else if (take_fire) begin
      take_total <= take_total + 1'b1;
    end
  end

endmodule

// File: rtl/irq_hist_checker.sv
module irq_hist_checker
  import irq_hist_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int POS_W  = PTR_W + 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [HIST_TS_W-1:0]              cycle_now,
  input logic [NUM_SRC-1:0]                raise_pulse,
  input logic                              take_fire,
  input logic [IDX_W-1:0]                  take_idx,
  input logic [PTR_W-1:0]                  wr_ptr,
  input logic [NUM_SRC-1:0][HIST_TS_W-1:0] stamp_q,
  input logic [POS_W-1:0]                  rd_pos,
  input logic                              rd_vld,
  input logic [IDX_W-1:0]                  rd_idx,
  input logic [HIST_TS_W-1:0]              rd_gap,
  input logic [CNT_W-1:0]                  take_total
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_stamp
    assert_stamp_load_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      raise_pulse[s] |=> stamp_q[s] == $past(cycle_now));
  end

  assert_newest_entry_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && cycle_now != '0) |=> (rd_pos != '0) || (rd_vld && rd_idx == $past(take_idx)));

  assert_ptr_wrap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && wr_ptr == PTR_W'(DEPTH - 1)) |=> wr_ptr == '0);

  assert_ptr_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && wr_ptr != PTR_W'(DEPTH - 1)) |=> wr_ptr == $past(wr_ptr) + 1'b1);

  assert_ptr_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !take_fire |=> $stable(wr_ptr));

  assert_out_of_range_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_pos) >= 32'(DEPTH)) |-> !rd_vld);

  assert_first_gap_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pos == '0) |-> rd_gap == '0);

  assert_total_step_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> take_total == $past(take_total) + 1'b1);

  assert_total_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !take_fire |=> $stable(take_total));

endmodule

bind irq_hist_recorder irq_hist_checker #(
  .NUM_SRC (NUM_SRC),
  .DEPTH   (DEPTH),
  .CNT_W   (CNT_W)
) checker_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_now   (cycle_now),
  .raise_pulse (raise_pulse),
  .take_fire   (take_fire),
  .take_idx    (take_idx),
  .wr_ptr      (wr_ptr),
  .stamp_q     (stamp_q),
  .rd_pos      (rd_pos),
  .rd_vld      (rd_vld),
  .rd_idx      (rd_idx),
  .rd_gap      (rd_gap),
  .take_total  (take_total)
);

// File: tb/irq_hist_recorder_tb_top.sv
module irq_hist_recorder_tb_top;
  import irq_hist_pkg::*;

  localparam int NS    = 8;
  localparam int DEPTH = 16;
  localparam int CNT_W = 32;
  localparam int IDX_W = 3;
  localparam int POS_W = 5;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [31:0]        cycle_now = '0;
  logic [NS-1:0]      raise_pulse = '0;
  logic               take_vld = 1'b0;
  logic [IDX_W-1:0]   take_idx = '0;
  logic [POS_W-1:0]   rd_pos = '0;
  logic               rd_vld;
  logic [IDX_W-1:0]   rd_idx;
  logic [31:0]        rd_latency;
  logic [31:0]        rd_gap;
  logic [CNT_W-1:0]   take_total;

  int errors = 0;
  int checks = 0;
  int unsigned tnow = 1;

  // Bench-side record of what the requirements say should be held.
  int unsigned m_stamp  [NS];
  int unsigned m_idx    [DEPTH];
  int unsigned m_taken  [DEPTH];
  int unsigned m_raised [DEPTH];
  int unsigned m_wr;
  int unsigned m_total;

  always #2 clk = ~clk;

  irq_hist_recorder #(.NUM_SRC(NS), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now), .raise_pulse(raise_pulse),
    .take_vld(take_vld), .take_idx(take_idx), .rd_pos(rd_pos), .rd_vld(rd_vld),
    .rd_idx(rd_idx), .rd_latency(rd_latency), .rd_gap(rd_gap), .take_total(take_total)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    raise_pulse = '0;
    take_vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < NS; s++) m_stamp[s] = 0;
    for (int k = 0; k < DEPTH; k++) begin
      m_idx[k] = 0; m_taken[k] = 0; m_raised[k] = 0;
    end
    m_wr = 0;
    m_total = 0;
  endtask

  // One clock: optional requests and an optional take, model updated alongside.
  task automatic step(input logic [NS-1:0] rv, input bit tk, input int ti);
    @(negedge clk);
    raise_pulse = rv;
    take_vld = tk;
    take_idx = IDX_W'(ti);
    cycle_now = tnow;
    if (tk) begin
      m_idx[m_wr] = ti;
      m_taken[m_wr] = tnow;
      m_raised[m_wr] = m_stamp[ti];
      m_wr = (m_wr + 1) % DEPTH;
      m_total = m_total + 1;
    end
    for (int s = 0; s < NS; s++) if (rv[s]) m_stamp[s] = tnow;
    @(posedge clk);
    #1;
    raise_pulse = '0;
    take_vld = 1'b0;
    tnow = tnow + 1;
  endtask

  // Read every position plus one past the end and compare with the model.
  task automatic check_all(input string tag);
    bit live;
    int unsigned prev_taken;
    live = 1'b1;
    prev_taken = 0;
    for (int p = 0; p <= DEPTH; p++) begin
      int unsigned slot;
      int unsigned e_lat, e_gap, e_idx;
      bit e_vld;
      slot = (m_wr + DEPTH - 1 - (p % DEPTH)) % DEPTH;
      live = live && (p < DEPTH) && (m_taken[slot] != 0);
      e_vld = live;
      e_idx = e_vld ? m_idx[slot] : 0;
      e_lat = e_vld ? m_taken[slot] - m_raised[slot] : 0;
      e_gap = (e_vld && p > 0) ? prev_taken - m_taken[slot] : 0;
      rd_pos = POS_W'(p);
      #1;
      chk(rd_vld == e_vld, {tag, " R6 valid"}, rd_vld, e_vld);
      chk(rd_idx == IDX_W'(e_idx), {tag, " R5 index"}, rd_idx, e_idx);
      chk(rd_latency == e_lat, {tag, " R1/R7 latency"}, rd_latency, e_lat);
      chk(rd_gap == e_gap, {tag, " R8 gap"}, rd_gap, e_gap);
      if (p < DEPTH) prev_taken = m_taken[slot];
    end
    rd_pos = '0;
    chk(take_total == m_total, {tag, " R9 total"}, take_total, m_total);
  endtask

  task automatic t_reset();
    do_reset();
    rd_pos = '0;
    #1;
    chk(rd_vld == 1'b0, "R4 empty after reset", rd_vld, 0);
    chk(take_total == '0, "R4 total after reset", take_total, 0);
    check_all("reset");
  endtask

  task automatic t_basic_latency();
    step(8'b0000_1000, 1'b0, 0);
    repeat (14) step('0, 1'b0, 0);
    step('0, 1'b1, 3);
    rd_pos = '0;
    #1;
    chk(rd_vld && rd_latency == 32'd15, "R7 single latency", rd_latency, 15);
    chk(rd_idx == 3'd3, "R2 single index", rd_idx, 3);
    check_all("basic");
  endtask

  task automatic t_same_edge();
    int unsigned first_raise;
    first_raise = tnow;
    step(8'b0000_0100, 1'b0, 0);
    repeat (4) step('0, 1'b0, 0);
    step(8'b0000_0100, 1'b1, 2);
    rd_pos = '0;
    #1;
    chk(rd_latency == (tnow - 1) - first_raise, "R2 same-edge uses old stamp",
        rd_latency, (tnow - 1) - first_raise);
    repeat (2) step('0, 1'b0, 0);
    step('0, 1'b1, 2);
    rd_pos = '0;
    #1;
    chk(rd_latency == 32'd3, "R1 stamp from same-edge request", rd_latency, 3);
    check_all("same_edge");
  endtask

  task automatic t_gaps();
    step(8'b1111_0000, 1'b0, 0);
    step('0, 1'b1, 4);
    repeat (3) step('0, 1'b0, 0);
    step('0, 1'b1, 5);
    step('0, 1'b1, 6);
    repeat (7) step('0, 1'b0, 0);
    step('0, 1'b1, 7);
    rd_pos = POS_W'(1);
    #1;
    chk(rd_gap == 32'd8, "R8 gap to newer", rd_gap, 8);
    check_all("gaps");
  endtask

  task automatic t_wrap();
    int unsigned fourth;
    do_reset();
    for (int n = 0; n < DEPTH + 3; n++) begin
      step(NS'(1) << (n % NS), 1'b0, 0);
      step('0, 1'b1, n % NS);
    end
    fourth = 3 % NS;
    rd_pos = POS_W'(DEPTH - 1);
    #1;
    chk(rd_vld && rd_idx == IDX_W'(fourth), "R3 oldest after wrap", rd_idx, fourth);
    rd_pos = '0;
    #1;
    chk(rd_idx == IDX_W'((DEPTH + 2) % NS), "R5 newest after wrap", rd_idx, (DEPTH + 2) % NS);
    check_all("wrap");
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_latency();
    t_same_edge();
    t_gaps();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule